// File: doc/BRIEF.md
# Dual-Request Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines and presents them to a processor on two request outputs: a normal request and a fast request. Each output has its own enable mask. The same pending sources feed both outputs, so software decides per line which request, if any, a line raises. Nothing is latched from the source lines themselves. A status bit follows its line for as long as the line is high and enabled.

A simple word-wide register port gives software four kinds of access:
- masked and raw views of the pending sources;
- separate set-only and clear-only ports for each enable mask, so that one mask change never races another;
- a software-driven pending register, whose bits join the hardware lines in the raw view.

A build-time mask names the lines that exist. Lines that are not implemented stay invisible. Software finds the source itself by scanning the masked status word, which makes the block purely combinational apart from its masks, its software bits and two output flops.

Top module: `dual_intc`

## Requirements
- R1: After reset both enable masks and all software pending bits are zero, both request outputs are low, and every status word reads zero while all source lines are low.
- R2: A write to byte offset 0x08 sets each normal-request enable bit whose written bit is 1. Enable bits written as 0 keep their value.
- R3: A write to byte offset 0x0C clears each normal-request enable bit whose written bit is 1. Enable bits written as 0 keep their value.
- R4: A read of offset 0x00 returns the raw pending word ANDed with the normal-request enable mask. Because the sources are level-sensitive, a bit follows its line in the same cycle, with no latching.
- R5: Reads of offsets 0x04 and 0x24 both return the raw pending word. That word is the source lines ORed with the software pending bits, restricted to the implemented lines.
- R6: The fast-request path has its own enable mask, independent of the normal one. Offset 0x28 sets bits (write-one), offset 0x2C clears bits (write-one), a read of 0x28 returns the fast enable mask, and a read of 0x20 returns the raw word ANDed with that mask.
- R7: Writing a 1 to bit n at offset 0x10 sets software pending bit n. Writing a 1 to bit n at offset 0x14 clears it. Bits written as 0 at either offset are left alone.
- R8: `irqOut` equals the OR of the normal masked status and `fiqOut` equals the OR of the fast masked status, each delayed by exactly one clock.
- R9: Bits of lines that are cleared in `VALID_MASK` read as zero in every status word, and writes to their enable or software bits have no effect.
- R10: Reads of offsets 0x08, 0x0C, 0x10, 0x14, 0x2C, of any other unmapped offset, and of any offset whose low two bits are not zero return zero. A write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Level-sensitive interrupt lines |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one write per cycle it is high |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Registered normal interrupt request |
| fiqOut | output | 1 | Registered fast interrupt request |

## Verification
The source lines are driven with all-ones, single-bit and all-zero patterns against enable masks that only partly overlap them. This separates the masked view from the raw view and shows the normal and fast masks acting independently. Software pending bits are raised and lowered while the lines are low, which shows that they merge into the raw view and can be released one at a time. Writes with bits on lines that are not implemented, and reads of the write-only offsets, confirm those paths stay at zero. Dropping a line just before a clock edge shows the one-cycle latency of the request outputs.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Byte offsets of the register port; software relies on these values.
  localparam logic [5:0] OFS_IRQ_STAT  = 6'h00;
  localparam logic [5:0] OFS_RAW       = 6'h04;
  localparam logic [5:0] OFS_IRQ_SET   = 6'h08;
  localparam logic [5:0] OFS_IRQ_CLR   = 6'h0C;
  localparam logic [5:0] OFS_SOFT_SET  = 6'h10;
  localparam logic [5:0] OFS_SOFT_CLR  = 6'h14;
  localparam logic [5:0] OFS_FIQ_STAT  = 6'h20;
  localparam logic [5:0] OFS_FIQ_RAW   = 6'h24;
  localparam logic [5:0] OFS_FIQ_SET   = 6'h28;
  localparam logic [5:0] OFS_FIQ_CLR   = 6'h2C;

  // Index of each set/clear register bank in the datapath.
  localparam int BANK_IRQ  = 0;
  localparam int BANK_FIQ  = 1;
  localparam int BANK_SOFT = 2;
  localparam int NUM_BANKS = 3;

  // Write strobes from control to datapath.
  typedef struct packed {
    logic irqEnSet;
    logic irqEnClr;
    logic fiqEnSet;
    logic fiqEnClr;
    logic softSet;
    logic softClr;
  } wrStrobe_t;

  // Read data select.
  typedef enum logic [2:0] {
    RD_ZERO,
    RD_IRQ_STAT,
    RD_RAW,
    RD_FIQ_STAT,
    RD_FIQ_EN
  } rdSel_t;

endpackage

// File: rtl/intc_mask_reg.sv
// One enable-style register with separate set and clear write ports.
module intc_mask_reg #(
  parameter int              WIDTH = 32,
  parameter logic [WIDTH-1:0] KEEP = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setEn,
  input  logic             clrEn,
  input  logic [WIDTH-1:0] wrBits,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] nextQ;

  always_comb begin
    nextQ = q;
    if (setEn) nextQ = q | (wrBits & KEEP);
    else if (clrEn) nextQ = q & ~wrBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= nextQ & KEEP;
  end

endmodule

// File: rtl/intc_ctrl.sv
// Address decode: turns bus accesses into write strobes and a read select.
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output wrStrobe_t         strobes,
  output rdSel_t            rdSel
);

  localparam int OFS_W = 6;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [OFS_W-1:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    strobes          = '0;
    strobes.irqEnSet = busWrEn && hit(busAddr, OFS_IRQ_SET);
    strobes.irqEnClr = busWrEn && hit(busAddr, OFS_IRQ_CLR);
    strobes.fiqEnSet = busWrEn && hit(busAddr, OFS_FIQ_SET);
    strobes.fiqEnClr = busWrEn && hit(busAddr, OFS_FIQ_CLR);
    strobes.softSet  = busWrEn && hit(busAddr, OFS_SOFT_SET);
    strobes.softClr  = busWrEn && hit(busAddr, OFS_SOFT_CLR);
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (hit(busAddr, OFS_IRQ_STAT))      rdSel = RD_IRQ_STAT;
    else if (hit(busAddr, OFS_RAW))      rdSel = RD_RAW;
    else if (hit(busAddr, OFS_FIQ_RAW))  rdSel = RD_RAW;
    else if (hit(busAddr, OFS_FIQ_STAT)) rdSel = RD_FIQ_STAT;
    else if (hit(busAddr, OFS_FIQ_SET))  rdSel = RD_FIQ_EN;
  end

endmodule

// File: rtl/intc_datapath.sv
// Enable masks, software pending bits, status words and request flops.
module intc_datapath
  import intc_pkg::*;
#(
  parameter int                 NUM_SRC    = 32,
  parameter int                 DATA_W     = 32,
  parameter logic [NUM_SRC-1:0] VALID_MASK = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [DATA_W-1:0]  busWrData,
  input  wrStrobe_t          strobes,
  input  rdSel_t             rdSel,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic [NUM_SRC-1:0] rawBits,
  output logic [NUM_SRC-1:0] irqEnMask,
  output logic [NUM_SRC-1:0] fiqEnMask
);

  logic [NUM_BANKS-1:0] setVec;
  logic [NUM_BANKS-1:0] clrVec;
  logic [NUM_SRC-1:0]   bankQ [NUM_BANKS];
  logic [NUM_SRC-1:0]   wrBits;
  logic [NUM_SRC-1:0]   softBits;
  logic [NUM_SRC-1:0]   irqStat;
  logic [NUM_SRC-1:0]   fiqStat;

  assign wrBits = busWrData[NUM_SRC-1:0];

  assign setVec[BANK_IRQ]  = strobes.irqEnSet;
  assign clrVec[BANK_IRQ]  = strobes.irqEnClr;
  assign setVec[BANK_FIQ]  = strobes.fiqEnSet;
  assign clrVec[BANK_FIQ]  = strobes.fiqEnClr;
  assign setVec[BANK_SOFT] = strobes.softSet;
  assign clrVec[BANK_SOFT] = strobes.softClr;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    intc_mask_reg #(
      .WIDTH (NUM_SRC),
      .KEEP  (VALID_MASK)
    ) u_reg (
      .clk    (clk),
      .rstN   (rstN),
      .setEn  (setVec[g]),
      .clrEn  (clrVec[g]),
      .wrBits (wrBits),
      .q      (bankQ[g])
    );
  end

  assign irqEnMask = bankQ[BANK_IRQ];
  assign fiqEnMask = bankQ[BANK_FIQ];
  assign softBits  = bankQ[BANK_SOFT];

  assign rawBits = (srcIn | softBits) & VALID_MASK;
  assign irqStat = rawBits & irqEnMask;
  assign fiqStat = rawBits & fiqEnMask;

  always_comb begin
    unique case (rdSel)
      RD_IRQ_STAT: busRdData = DATA_W'(irqStat);
      RD_RAW:      busRdData = DATA_W'(rawBits);
      RD_FIQ_STAT: busRdData = DATA_W'(fiqStat);
      RD_FIQ_EN:   busRdData = DATA_W'(fiqEnMask);
      default:     busRdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      irqOut <= |irqStat;
      fiqOut <= |fiqStat;
    end
  end

endmodule

// File: rtl/dual_intc.sv
module dual_intc
  import intc_pkg::*;
#(
  parameter int                 NUM_SRC    = 32,
  parameter int                 ADDR_W     = 6,
  parameter int                 DATA_W     = 32,
  parameter logic [NUM_SRC-1:0] VALID_MASK = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqOut,
  output logic               fiqOut
);

  wrStrobe_t          strobes;
  rdSel_t             rdSel;
  logic [NUM_SRC-1:0] rawBits;
  logic [NUM_SRC-1:0] irqEnMask;
  logic [NUM_SRC-1:0] fiqEnMask;

  intc_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  intc_datapath #(
    .NUM_SRC    (NUM_SRC),
    .DATA_W     (DATA_W),
    .VALID_MASK (VALID_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .busWrData (busWrData),
    .strobes   (strobes),
    .rdSel     (rdSel),
    .busRdData (busRdData),
    .irqOut    (irqOut),
    .fiqOut    (fiqOut),
    .rawBits   (rawBits),
    .irqEnMask (irqEnMask),
    .fiqEnMask (fiqEnMask)
  );

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int                 NUM_SRC    = 32,
  parameter int                 ADDR_W     = 6,
  parameter int                 DATA_W     = 32,
  parameter logic [NUM_SRC-1:0] VALID_MASK = '1
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [DATA_W-1:0]  busWrData,
  input logic               irqOut,
  input logic               fiqOut,
  input logic [NUM_SRC-1:0] rawBits,
  input logic [NUM_SRC-1:0] irqEnMask,
  input logic [NUM_SRC-1:0] fiqEnMask
);

  logic [NUM_SRC-1:0] wd;
  logic               wrIrqSet, wrIrqClr, wrFiqAny;

  assign wd       = busWrData[NUM_SRC-1:0] & VALID_MASK;
  assign wrIrqSet = busWrEn && busAddr == ADDR_W'(6'h08);
  assign wrIrqClr = busWrEn && busAddr == ADDR_W'(6'h0C);
  assign wrFiqAny = busWrEn && (busAddr == ADDR_W'(6'h28) || busAddr == ADDR_W'(6'h2C));

  a_r2_irq_set: assert property (@(posedge clk) disable iff (!rstN)
    wrIrqSet |=> irqEnMask == ($past(irqEnMask) | $past(wd)));

  a_r3_irq_clr: assert property (@(posedge clk) disable iff (!rstN)
    wrIrqClr |=> irqEnMask == ($past(irqEnMask) & ~$past(wd)));

  a_r6_fiq_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrFiqAny |=> $stable(fiqEnMask));

  a_r8_irq_latency: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == $past(|(rawBits & irqEnMask)));

  a_r8_fiq_latency: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> fiqOut == $past(|(rawBits & fiqEnMask)));

  a_r9_invalid_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((rawBits | irqEnMask | fiqEnMask) & ~VALID_MASK) == '0);

endmodule

bind dual_intc intc_checker #(
  .NUM_SRC    (NUM_SRC),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .VALID_MASK (VALID_MASK)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .irqOut    (irqOut),
  .fiqOut    (fiqOut),
  .rawBits   (rawBits),
  .irqEnMask (irqEnMask),
  .fiqEnMask (fiqEnMask)
);

// File: tb/test_dual_intc.sv
module test_dual_intc;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VMASK = 32'hF0FF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut, fiqOut;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_intc #(.VALID_MASK(VMASK)) i_dual_intc (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    srcIn = '0;
    @(negedge clk);
    chk("R1 irqOut", {31'b0, irqOut}, 0);
    chk("R1 fiqOut", {31'b0, fiqOut}, 0);
    rdChk("R1 irq status", 6'h00, 0);
    rdChk("R1 raw", 6'h04, 0);
    rdChk("R1 fiq enable", 6'h28, 0);
    srcIn = '1;
    rdChk("R1 masked with no enables", 6'h00, 0);
    rdChk("R5 raw 0x04", 6'h04, VMASK);
    rdChk("R5 raw 0x24", 6'h24, VMASK);
    srcIn = '0;
  endtask

  task automatic t_irqEnable();
    srcIn = '1;
    wr(6'h08, 32'h0000_00F0);
    wr(6'h08, 32'h0000_0003);
    rdChk("R2 set keeps zeros", 6'h00, 32'h0000_00F3);
    wr(6'h0C, 32'h0000_0010);
    rdChk("R3 clear one bit", 6'h00, 32'h0000_00E3);
    rdChk("R6 fiq independent", 6'h20, 0);
    @(negedge clk);
    chk("R8 irqOut high", {31'b0, irqOut}, 1);
    chk("R6 fiqOut low", {31'b0, fiqOut}, 0);
  endtask

  task automatic t_level();
    srcIn = 32'h0000_0002;
    rdChk("R4 single line", 6'h00, 32'h0000_0002);
    @(negedge clk);
    chk("R8 irqOut for single line", {31'b0, irqOut}, 1);
    srcIn = 32'h0000_0000;
    rdChk("R4 line dropped", 6'h00, 0);
    chk("R8 irqOut still high before edge", {31'b0, irqOut}, 1);
    @(negedge clk);
    chk("R8 irqOut low one clock later", {31'b0, irqOut}, 0);
  endtask

  task automatic t_fiq();
    wr(6'h28, 32'h0000_0F00);
    rdChk("R6 fiq enable readback", 6'h28, 32'h0000_0F00);
    srcIn = 32'h0000_0300;
    rdChk("R6 fiq status", 6'h20, 32'h0000_0300);
    rdChk("R4 irq status unaffected", 6'h00, 0);
    @(negedge clk);
    chk("R8 fiqOut high", {31'b0, fiqOut}, 1);
    chk("R8 irqOut low", {31'b0, irqOut}, 0);
    wr(6'h2C, 32'h0000_0100);
    rdChk("R6 fiq clear", 6'h28, 32'h0000_0E00);
    rdChk("R6 fiq status after clear", 6'h20, 32'h0000_0200);
    srcIn = '0;
  endtask

  task automatic t_soft();
    wr(6'h10, 32'h0000_0041);
    rdChk("R7 soft raw 0x04", 6'h04, 32'h0000_0041);
    rdChk("R7 soft raw 0x24", 6'h24, 32'h0000_0041);
    rdChk("R7 soft masked", 6'h00, 32'h0000_0041);
    @(negedge clk);
    chk("R7 soft raises irqOut", {31'b0, irqOut}, 1);
    wr(6'h14, 32'h0000_0001);
    rdChk("R7 soft clear one", 6'h04, 32'h0000_0040);
    wr(6'h14, 32'h0000_0040);
    rdChk("R7 soft all cleared", 6'h04, 0);
  endtask

  task automatic t_invalid();
    wr(6'h08, 32'h0F00_0000);
    wr(6'h28, 32'h0F00_0000);
    wr(6'h10, 32'h0F00_0000);
    srcIn = '0;
    rdChk("R9 soft on missing lines", 6'h04, 0);
    rdChk("R9 fiq enable ignores missing", 6'h28, 32'h0000_0E00);
    srcIn = 32'h0F00_0000;
    rdChk("R9 raw hides missing lines", 6'h04, 0);
    rdChk("R9 irq status hides missing", 6'h00, 0);
    rdChk("R9 fiq status hides missing", 6'h20, 0);
    @(negedge clk);
    chk("R9 irqOut stays low", {31'b0, irqOut}, 0);
    srcIn = '0;
  endtask

  task automatic t_writeOnly();
    srcIn = '1;
    rdChk("R10 read 0x08", 6'h08, 0);
    rdChk("R10 read 0x0C", 6'h0C, 0);
    rdChk("R10 read 0x10", 6'h10, 0);
    rdChk("R10 read 0x14", 6'h14, 0);
    rdChk("R10 read 0x2C", 6'h2C, 0);
    rdChk("R10 read 0x18", 6'h18, 0);
    rdChk("R10 read misaligned", 6'h01, 0);
    wr(6'h09, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rdChk("R10 ignored writes", 6'h00, 32'h0000_00E3);
    srcIn = '0;
  endtask

  task automatic t_resetMid();
    wr(6'h10, 32'h0000_0004);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    srcIn = '1;
    rdChk("R1 irq mask cleared", 6'h00, 0);
    rdChk("R1 fiq mask cleared", 6'h28, 0);
    srcIn = '0;
    rdChk("R1 soft cleared", 6'h04, 0);
    @(negedge clk);
    chk("R1 irqOut after reset", {31'b0, irqOut}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_irqEnable();
    t_level();
    t_fiq();
    t_soft();
    t_invalid();
    t_writeOnly();
    t_resetMid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule